// File: doc/BRIEF.md
# Response Halfword Readout Buffer

This block sits between the command-line receiver of a card host controller and the register file that software reads. The receiver delivers a command response as a train of 16-bit halfwords, most significant first. Once the receiver signals that the response is complete, the block freezes what it holds. Software then pulls the response out through one read port, one halfword per read strobe. Every strobe moves on to the next halfword, so the same address is read again and again.

A short response carries 40 content bits and takes three halfwords. A long response carries a header byte and a 128-bit payload and takes nine halfwords, with the payload shifted by one byte across them. Software rebuilds each 32-bit word from three neighbouring halfwords. The block neither repacks nor checks the bits. It stores, freezes, sequences and guards.

A three-state controller governs the block:
- `ST_IDLE` is the state after reset.
- `ST_FILL` is entered on a command start from any state. In it, halfwords are accepted.
- `ST_HOLD` is entered from `ST_FILL` on response done. In it, contents are frozen and readable.

The transitions are named `T_START` (any state to `ST_FILL`), `T_DONE` (`ST_FILL` to `ST_HOLD`) and `T_STAY` (no change).

Top module: `rsp_halfword_buf`

## Requirements
- R1: After reset the block is in `ST_IDLE`, `rsp_ready` is 0 and `rd_data` is 0.
- R2: In `ST_FILL`, each cycle with `wr_valid` high stores `wr_half` in the next entry, starting at entry 0. Entries are later read back in write order.
- R3: `rsp_done` in `ST_FILL` raises `rsp_ready` from the following cycle. From then on, `wr_valid` changes no stored value and no count. `rsp_done` outside `ST_FILL` is ignored.
- R4: In `ST_HOLD`, `rd_data` shows the entry at the read pointer, and the first value shown is entry 0. Each `rd_strobe` advances the pointer by one entry while it is below the number of stored halfwords.
- R5: Once every stored halfword has been read, `rd_data` is 0 and further strobes leave the pointer where it is.
- R6: `cmd_start` takes priority over `rsp_done`, `wr_valid` and `rd_strobe` in the same cycle. From any state it sets the read pointer to entry 0, empties the buffer and clears `rsp_ready`.
- R7: Outside `ST_HOLD`, `rd_data` is 0 and `rd_strobe` does not move the pointer.
- R8: The buffer holds at most DEPTH (9) halfwords. Writes beyond that in the same fill are dropped.
- R9: A long response is packed as nine halfwords of a 144-bit stream: the header byte, then the 128-bit payload, then 8 zero bits. Word i (i = 0 for the most significant) reads back as {low byte of halfword 2i, halfword 2i+1, high byte of halfword 2i+2}. A short response is packed as bits [39:24], then [23:8], then {[7:0], 8'h00}, and reads back the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | New command started: restart the fill |
| wr_valid | input | 1 | Receiver halfword valid |
| wr_half | input | 16 | Receiver halfword |
| rsp_done | input | 1 | Response complete: freeze contents |
| rd_strobe | input | 1 | Software read: pop one halfword |
| rd_data | output | 16 | Halfword at the read pointer, or 0 |
| rsp_ready | output | 1 | Contents valid for reading |

## Verification
The bench sweeps fill lengths from zero to beyond the depth, and checks every halfword and the zero that follows the last one.
- An overflowing store would corrupt entries or read back too many values.
- A pointer that runs past the count would return stale data instead of zero.
- A premature read that advanced the pointer would skip entry 0.

Further scenarios cover writes arriving after the freeze and a restart in the middle of a readout. A start that coincides with done must leave `rsp_ready` low. Word reconstruction is checked for a long and a short response, which catches any byte swap or reordering inside the store.

// File: rtl/rspbuf_pkg.sv
package rspbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } rsp_state_e;

    typedef enum logic [1:0] {
        T_STAY  = 2'd0,
        T_START = 2'd1,
        T_DONE  = 2'd2
    } rsp_trans_e;

endpackage

// File: rtl/rspbuf_ctrl.sv
module rspbuf_ctrl
    import rspbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic rsp_done,
    output logic fill_en,
    output logic hold,
    output logic ready
);

    rsp_state_e state_q;
    rsp_state_e state_d;
    rsp_trans_e trans;

    // transition selection; start has the highest priority
    always_comb begin
        trans   = T_STAY;
        state_d = state_q;
        if (cmd_start) begin
            trans   = T_START;
            state_d = ST_FILL;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FILL: begin
                    if (rsp_done) begin
                        trans   = T_DONE;
                        state_d = ST_HOLD;
                    end
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fill_en = 1'b0;
        hold    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: fill_en = 1'b1;
            ST_HOLD: hold    = 1'b1;
            default: ;
        endcase
        ready = hold;
    end

    AST_DONE_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (trans == T_DONE) |=> (state_q == ST_HOLD)); // R3

    AST_START_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (state_q == ST_FILL)); // R6

endmodule

// File: rtl/rspbuf_store.sv
module rspbuf_store #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 9,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fill_en,
    input  logic              wr_valid,
    input  logic [HALF_W-1:0] wr_half,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [HALF_W-1:0] rd_entry,
    output logic [PTR_W-1:0]  count
);

    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0]  cnt_q;
    logic              accept;
    logic [HALF_W-1:0] mem [DEPTH];

    assign accept = fill_en && !clear && wr_valid && (cnt_q < FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (accept && (cnt_q == PTR_W'(g)))
                mem[g] <= wr_half;
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == PTR_W'(k)) rd_entry = mem[k];
        end
    end

    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R8

    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !clear) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/rspbuf_rdport.sv
module rspbuf_rdport #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 9,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              hold,
    input  logic              rd_strobe,
    input  logic [PTR_W-1:0]  count,
    input  logic [HALF_W-1:0] entry,
    output logic [PTR_W-1:0]  rd_idx,
    output logic [HALF_W-1:0] rd_data
);

    logic [PTR_W-1:0] ptr_q;
    logic             avail;

    assign avail = hold && (ptr_q < count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ptr_q <= '0;
        else if (clear)                  ptr_q <= '0;
        else if (rd_strobe && avail)     ptr_q <= ptr_q + 1'b1;
    end

    assign rd_idx  = ptr_q;
    assign rd_data = avail ? entry : '0;

    AST_PTR_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= count); // R5

    AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !clear) |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/rsp_halfword_buf.sv
module rsp_halfword_buf #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              wr_valid,
    input  logic [HALF_W-1:0] wr_half,
    input  logic              rsp_done,
    input  logic              rd_strobe,
    output logic [HALF_W-1:0] rd_data,
    output logic              rsp_ready
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    logic              fill_en;
    logic              hold;
    logic [PTR_W-1:0]  count;
    logic [PTR_W-1:0]  rd_idx;
    logic [HALF_W-1:0] entry;

    rspbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .rsp_done  (rsp_done),
        .fill_en   (fill_en),
        .hold      (hold),
        .ready     (rsp_ready)
    );

    rspbuf_store #(.HALF_W(HALF_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_start),
        .fill_en  (fill_en),
        .wr_valid (wr_valid),
        .wr_half  (wr_half),
        .rd_idx   (rd_idx),
        .rd_entry (entry),
        .count    (count)
    );

    rspbuf_rdport #(.HALF_W(HALF_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cmd_start),
        .hold      (hold),
        .rd_strobe (rd_strobe),
        .count     (count),
        .entry     (entry),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    AST_ZERO_UNLESS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (rd_data == '0)); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!rsp_ready && rd_idx == '0 && count == '0)); // R6

    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_ready) |-> $past(rsp_done)); // R3

endmodule

// File: tb/rsp_halfword_buf_tb.sv
module rsp_halfword_buf_tb;

    localparam int DEPTH = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_half = '0;
    logic        rsp_done = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic        rsp_ready;

    int vecs = 0;
    int miss = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rsp_halfword_buf #(.HALF_W(16), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .wr_valid  (wr_valid),
        .wr_half   (wr_half),
        .rsp_done  (rsp_done),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rsp_ready (rsp_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] h);
        @(negedge clk); wr_valid = 1'b1; wr_half = h;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic do_done();
        @(negedge clk); rsp_done = 1'b1;
        @(negedge clk); rsp_done = 1'b0;
    endtask

    // check current halfword, then pop it
    task automatic pop(input string req, input logic [15:0] exp, output logic [15:0] got);
        @(negedge clk); #1;
        got = rd_data;
        chk(req, {16'h0, rd_data}, {16'h0, exp});
        rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int n, input int i);
        return 16'((n * 16'h1357) ^ (i * 16'h0A1B) ^ (i + 1));
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            miss++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        logic [15:0] hw [9];
        logic [143:0] stream;
        logic [127:0] payload;
        logic [39:0] shortv;

        #1;
        chk("R1 ready", {31'h0, rsp_ready}, 32'h0);
        chk("R1 data", {16'h0, rd_data}, 32'h0);
        #9; rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ready after release", {31'h0, rsp_ready}, 32'h0);
        chk("R1 data after release", {16'h0, rd_data}, 32'h0);

        // R2 R4 R5 R8: sweep fill lengths 0..DEPTH+2
        for (int n = 0; n <= DEPTH + 2; n++) begin
            do_start();
            for (int i = 0; i < n; i++) do_write(pat(n, i));
            do_done();
            #1;
            chk("R3 ready after done", {31'h0, rsp_ready}, 32'h1);
            for (int i = 0; i < ((n < DEPTH) ? n : DEPTH); i++)
                pop("R2 R4 R8 sweep readback", pat(n, i), g);
            pop("R5 past end", 16'h0, g);
            pop("R5 past end again", 16'h0, g);
        end

        // R7: reads in FILL return zero and do not advance
        do_start();
        do_write(16'hA1A1);
        do_write(16'hB2B2);
        pop("R7 read during fill", 16'h0, g);
        pop("R7 read during fill", 16'h0, g);
        do_done();
        pop("R7 first entry intact", 16'hA1A1, g);
        pop("R7 second entry", 16'hB2B2, g);

        // R3: writes and done after freeze ignored
        do_start();
        for (int i = 0; i < 3; i++) do_write(pat(50, i));
        do_done();
        do_write(16'hDEAD);
        do_write(16'hBEEF);
        do_done();
        for (int i = 0; i < 3; i++) pop("R3 frozen", pat(50, i), g);
        pop("R3 late write dropped", 16'h0, g);

        // R6: restart mid-readout
        do_start();
        for (int i = 0; i < 5; i++) do_write(pat(60, i));
        do_done();
        pop("R6 pre-restart", pat(60, 0), g);
        pop("R6 pre-restart", pat(60, 1), g);
        do_start();
        #1;
        chk("R6 ready cleared", {31'h0, rsp_ready}, 32'h0);
        do_write(16'h1111);
        do_write(16'h2222);
        do_done();
        pop("R6 new entry 0", 16'h1111, g);
        pop("R6 new entry 1", 16'h2222, g);
        pop("R6 old entries gone", 16'h0, g);

        // R6: start coinciding with done and a write
        do_start();
        do_write(16'h3333);
        @(negedge clk); cmd_start = 1'b1; rsp_done = 1'b1; wr_valid = 1'b1; wr_half = 16'h4444;
        @(negedge clk); cmd_start = 1'b0; rsp_done = 1'b0; wr_valid = 1'b0; #1;
        chk("R6 start beats done", {31'h0, rsp_ready}, 32'h0);
        do_done();
        pop("R6 buffer emptied by start", 16'h0, g);

        // R3: done in IDLE-like HOLD ignored already; done in HOLD after restart check
        // R9 long response stitching
        payload = {32'h89ABCDEF, 32'h01234567, 32'hFEDCBA98, 32'h76543210};
        stream  = {8'h3F, payload, 8'h00};
        do_start();
        for (int k = 0; k < 9; k++) do_write(stream[143 - 16*k -: 16]);
        do_done();
        for (int k = 0; k < 9; k++) pop("R9 long halfword", stream[143 - 16*k -: 16], hw[k]);
        for (int w = 0; w < 4; w++)
            chk("R9 long word", {hw[2*w][7:0], hw[2*w+1], hw[2*w+2][15:8]},
                payload[127 - 32*w -: 32]);

        // R9 short response
        shortv = 40'h1D_C0FF_EE42;
        do_start();
        do_write(shortv[39:24]);
        do_write(shortv[23:8]);
        do_write({shortv[7:0], 8'h00});
        do_done();
        for (int k = 0; k < 3; k++) pop("R9 short halfword", (k == 0) ? shortv[39:24] :
            (k == 1) ? shortv[23:8] : {shortv[7:0], 8'h00}, hw[k]);
        chk("R9 short rebuild", {hw[0], hw[1]}, shortv[39:8]);
        chk("R9 short low byte", {24'h0, hw[2][15:8]}, {24'h0, shortv[7:0]});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule